// File: doc/BRIEF.md
# PC-Indexed Reuse Distance Predictor

This block learns, per load instruction, how many filtered accesses usually pass before a block that instruction touched is touched again. On every read that reaches the managed cache level, it looks up the instruction address in a small set-associative table. One cycle later it returns the learned distance, or a "not confident" answer. A replacement engine outside the block uses that answer to estimate when each resident line will next be used.

Training needs no separate tracking structure. Each table entry carries one unverified sample: a block address plus the access time at which that address was seen. Every later read address is compared against all pending samples. A match yields the true distance, which is the current time minus the stamp. That distance then confirms or contradicts the owning entry.

A confidence counter decides whether the entry may answer. The stored distance is replaced only after the counter has been worn down to zero. The access-time counter is an input. The surrounding logic advances it once per read and never on a writeback.

Top module: `reuse_dist_predictor`

## Requirements
- R1: After reset, no table entry is valid and `pred_vld`, `pred_conf` and `pred_dist` are 0. The first read of any PC gets a non-confident answer.
- R2: An access with `acc_read`=0 produces no response, resolves no pending sample, allocates nothing and changes no entry.
- R3: For each read, `pred_vld` pulses on the following cycle. `pred_conf` is 1 only when the PC is present in the table with a confidence of 2 or more. `pred_dist` then carries the stored distance and is 0 otherwise. The answer reflects the table as it was before that read.
- R4: A read whose PC is not in the table allocates an entry with confidence 0 and stored distance 0, and takes that read as the entry's pending sample.
- R5: When a read address equals a pending sample address, the measured distance is (`acc_time` − stamp) mod 2^20. Two distances agree when the index of their highest set bit is equal, with 0 and 1 both counted as index 0. On agreement the 2-bit confidence increments, saturating at 3.
- R6: On disagreement, a nonzero confidence decrements and the stored distance is kept. At confidence 0, the stored distance is replaced by the measured one.
- R7: An entry holds at most one pending sample. While a sample is pending, reads of the same PC answer normally but do not take a new sample. A read by the owning PC that resolves the sample takes a fresh one.
- R8: A pending sample whose age reaches 2^20−1 resolves as a distance of 2^20−1 and is freed, even with no access present.
- R9: The set index is `acc_pc[4:0]` and the tag is the remaining upper bits; each set has 8 ways. A miss fills the lowest-numbered invalid way. If no way is invalid, it fills the least recently used way, where both hits and fills count as uses.
- R10: Sample matching covers the samples of all entries, so one PC's read can resolve another PC's sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_read | input | 1 | 1 = demand read, 0 = writeback (filtered out) |
| acc_pc | input | 32 | Address of the instruction causing the access |
| acc_addr | input | 32 | Block address of the access |
| acc_time | input | 20 | Global filtered-access time counter |
| pred_vld | output | 1 | Response strobe, one cycle after a read |
| pred_conf | output | 1 | The entry is confident enough to predict |
| pred_dist | output | 20 | Predicted reuse distance, 0 when not confident |

## Verification
A corrupted confidence counter or stored distance appears at the ports only on a later read of the same PC. It shows as a flipped `pred_conf` or a wrong `pred_dist`, possibly several reads after the fault. For this reason, the training sequences walk each counter across its thresholds and read the answer at every step. A lost or spurious pending sample is invisible at first. It surfaces after two or three further resolutions, as a confidence that rose or fell one step too many. The stimulus therefore includes writebacks, blocked resampling, cross-PC matches and time jumps to the saturation age, each followed by reads until the answer differs. A faulty recency order shows up only when a set overflows, as a trained PC that suddenly answers as if new.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  // Index of the highest set bit; 0 and 1 both map to 0.
  function automatic logic [5:0] msb_idx(input logic [31:0] v);
    msb_idx = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) msb_idx = 6'(i);
    end
  endfunction

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_AGREE = 2'd1,
    OUT_DIFF  = 2'd2
  } outcome_e;

endpackage

// File: rtl/rdp_rst_sync.sv
module rdp_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/rdp_lru.sv
module rdp_lru #(
  parameter int WAYS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    touch,
  input  logic [$clog2(WAYS)-1:0] touch_way,
  input  logic [WAYS-1:0]         way_valid,
  output logic [$clog2(WAYS)-1:0] victim
);
  localparam int WW = $clog2(WAYS);
  localparam logic [WW-1:0] OLDEST = WW'(WAYS - 1);

  logic [WW-1:0]   rank_q [WAYS];
  logic [WW-1:0]   rank_d [WAYS];
  logic [WAYS-1:0] oldest;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rank_d[w] = rank_q[w];
      if (touch) begin
        if (WW'(w) == touch_way)                rank_d[w] = '0;
        else if (rank_q[w] < rank_q[touch_way]) rank_d[w] = rank_q[w] + WW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) rank_q[w] <= WW'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) rank_q[w] <= rank_d[w];
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) oldest[w] = (rank_q[w] == OLDEST);
    victim = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (oldest[w]) victim = WW'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) victim = WW'(w);
    end
  end

  // R9
  lru_single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);

  // R9
  lru_touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> rank_q[$past(touch_way)] == '0);
endmodule

// File: rtl/rdp_entry.sv
module rdp_entry
  import rdp_pkg::*;
#(
  parameter int TAG_W  = 27,
  parameter int ADDR_W = 32,
  parameter int DIST_W = 20,
  parameter int CONF_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DIST_W-1:0] acc_time,
  input  logic              sel_hit,
  input  logic              sel_alloc,
  input  logic [TAG_W-1:0]  alloc_tag,
  output logic              e_valid,
  output logic [TAG_W-1:0]  e_tag,
  output logic [DIST_W-1:0] e_dist,
  output logic [CONF_W-1:0] e_conf
);
  localparam logic [DIST_W-1:0] DMAX = '1;
  localparam logic [CONF_W-1:0] CMAX = '1;

  logic              vld_q, vld_d, pend_q, pend_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [DIST_W-1:0] dist_q, dist_d, stime_q, stime_d, age;
  logic [CONF_W-1:0] conf_q, conf_d;
  logic [ADDR_W-1:0] saddr_q, saddr_d;
  logic              addr_match, aged_out, resolve, capture, data_en;
  outcome_e          outcome;

  assign age        = acc_time - stime_q;
  assign addr_match = pend_q && acc_rd && (saddr_q == acc_addr);
  assign aged_out   = pend_q && (age == DMAX);
  assign resolve    = vld_q && (addr_match || aged_out);
  assign capture    = sel_hit && (!pend_q || resolve);

  always_comb begin
    outcome = OUT_NONE;
    if (resolve) begin
      outcome = (msb_idx(32'(age)) == msb_idx(32'(dist_q))) ? OUT_AGREE : OUT_DIFF;
    end
  end

  always_comb begin
    vld_d   = vld_q;
    pend_d  = pend_q;
    tag_d   = tag_q;
    dist_d  = dist_q;
    conf_d  = conf_q;
    saddr_d = saddr_q;
    stime_d = stime_q;
    if (sel_alloc) begin
      vld_d   = 1'b1;
      pend_d  = 1'b1;
      tag_d   = alloc_tag;
      dist_d  = '0;
      conf_d  = '0;
      saddr_d = acc_addr;
      stime_d = acc_time;
    end else begin
      case (outcome)
        OUT_AGREE: if (conf_q != CMAX) conf_d = conf_q + CONF_W'(1);
        OUT_DIFF: begin
          if (conf_q == '0) dist_d = age;
          else              conf_d = conf_q - CONF_W'(1);
        end
        default: ;
      endcase
      if (resolve) pend_d = 1'b0;
      if (capture) begin
        pend_d  = 1'b1;
        saddr_d = acc_addr;
        stime_d = acc_time;
      end
    end
  end

  assign data_en = sel_alloc || resolve || capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      tag_q   <= tag_d;
      dist_q  <= dist_d;
      conf_q  <= conf_d;
      saddr_q <= saddr_d;
      stime_q <= stime_d;
    end
  end

  assign e_valid = vld_q;
  assign e_tag   = tag_q;
  assign e_dist  = dist_q;
  assign e_conf  = conf_q;

  // R6
  keep_dist_on_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == OUT_DIFF && conf_q != '0 && !sel_alloc) |=> $stable(dist_q));

  // R5
  conf_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == OUT_AGREE && conf_q == CMAX && !sel_alloc) |=> conf_q == CMAX);

  // R7
  one_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !resolve && !sel_alloc) |=> ($stable(stime_q) && $stable(saddr_q) && pend_q));

  // R8
  aged_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aged_out && !sel_hit && !sel_alloc) |=> !pend_q);

  // R4
  alloc_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_alloc |=> (vld_q && pend_q && conf_q == '0 && dist_q == '0));
endmodule

// File: rtl/reuse_dist_predictor.sv
module reuse_dist_predictor #(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int DIST_W  = 20,
  parameter int ENTRIES = 256,
  parameter int WAYS    = 8,
  parameter int CONF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_read,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DIST_W-1:0] acc_time,
  output logic              pred_vld,
  output logic              pred_conf,
  output logic [DIST_W-1:0] pred_dist
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = SET_W + WAY_W;
  localparam int TAG_W = PC_W - SET_W;
  localparam logic [CONF_W-1:0] CONF_MIN = CONF_W'(1) << (CONF_W - 1);

  logic              rst_sn;
  logic              acc_rd;
  logic [SET_W-1:0]  acc_set;
  logic [TAG_W-1:0]  acc_tag;

  logic              e_valid [ENTRIES];
  logic [TAG_W-1:0]  e_tag   [ENTRIES];
  logic [DIST_W-1:0] e_dist  [ENTRIES];
  logic [CONF_W-1:0] e_conf  [ENTRIES];
  logic [ENTRIES-1:0] sel_hit, sel_alloc;

  logic [WAYS-1:0]   way_hit;
  logic [WAY_W-1:0]  hit_way, vict;
  logic [DIST_W-1:0] hit_dist;
  logic [CONF_W-1:0] hit_conf;
  logic              any_hit;
  logic [WAY_W-1:0]  set_victim [SETS];
  logic [IDX_W-1:0]  idx;

  logic              pv_d, pc_d;
  logic [DIST_W-1:0] pd_d;

  rdp_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_sn));

  assign acc_rd  = acc_valid && acc_read;
  assign acc_set = acc_pc[SET_W-1:0];
  assign acc_tag = acc_pc[PC_W-1:SET_W];
  assign any_hit = |way_hit;
  assign vict    = set_victim[acc_set];

  // Tag compare over the ways of the addressed set.
  always_comb begin
    way_hit  = '0;
    hit_way  = '0;
    hit_dist = '0;
    hit_conf = '0;
    idx      = '0;
    for (int w = 0; w < WAYS; w++) begin
      idx = {acc_set, WAY_W'(w)};
      way_hit[w] = e_valid[idx] && (e_tag[idx] == acc_tag);
      if (way_hit[w]) begin
        hit_way  = WAY_W'(w);
        hit_dist = e_dist[idx];
        hit_conf = e_conf[idx];
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [SET_W-1:0] S_ID = SET_W'(e / WAYS);
    localparam logic [WAY_W-1:0] W_ID = WAY_W'(e % WAYS);

    assign sel_hit[e]   = acc_rd && (acc_set == S_ID) && way_hit[W_ID];
    assign sel_alloc[e] = acc_rd && !any_hit && (acc_set == S_ID) && (vict == W_ID);

    rdp_entry #(
      .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DIST_W(DIST_W), .CONF_W(CONF_W)
    ) u_ent (
      .clk       (clk),
      .rst_n     (rst_sn),
      .acc_rd    (acc_rd),
      .acc_addr  (acc_addr),
      .acc_time  (acc_time),
      .sel_hit   (sel_hit[e]),
      .sel_alloc (sel_alloc[e]),
      .alloc_tag (acc_tag),
      .e_valid   (e_valid[e]),
      .e_tag     (e_tag[e]),
      .e_dist    (e_dist[e]),
      .e_conf    (e_conf[e])
    );
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    localparam logic [SET_W-1:0] S_ID = SET_W'(s);
    logic [WAYS-1:0] vmask;
    logic            touch;

    for (genvar w = 0; w < WAYS; w++) begin : g_vm
      assign vmask[w] = e_valid[s * WAYS + w];
    end

    assign touch = acc_rd && (acc_set == S_ID);

    rdp_lru #(.WAYS(WAYS)) u_lru (
      .clk       (clk),
      .rst_n     (rst_sn),
      .touch     (touch),
      .touch_way (any_hit ? hit_way : vict),
      .way_valid (vmask),
      .victim    (set_victim[s])
    );
  end

  // Response stage.
  always_comb begin
    pv_d = acc_rd;
    pc_d = any_hit && (hit_conf >= CONF_MIN);
    pd_d = pc_d ? hit_dist : '0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pred_vld  <= 1'b0;
      pred_conf <= 1'b0;
      pred_dist <= '0;
    end else begin
      pred_vld <= pv_d;
      if (acc_rd) begin
        pred_conf <= pc_d;
        pred_dist <= pd_d;
      end
    end
  end

  // R9
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_rd |-> $onehot0(way_hit));

  // R4
  one_alloc_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_rd && !any_hit) |-> $countones(sel_alloc) == 1);

  // R2
  writeback_silent_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_valid && !acc_read) |=> !pred_vld);

  // R3
  idle_dist_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (pred_vld && !pred_conf) |-> pred_dist == '0);

  // R2
  no_touch_on_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !acc_rd |-> (sel_hit == '0 && sel_alloc == '0));
endmodule

// File: tb/reuse_dist_predictor_tb_top.sv
`timescale 1ns/1ps
module reuse_dist_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_read;
  logic [31:0] acc_pc, acc_addr;
  logic [19:0] acc_time;
  logic        pred_vld, pred_conf;
  logic [19:0] pred_dist;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  reuse_dist_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_read(acc_read),
    .acc_pc(acc_pc), .acc_addr(acc_addr), .acc_time(acc_time),
    .pred_vld(pred_vld), .pred_conf(pred_conf), .pred_dist(pred_dist)
  );

  typedef struct packed {
    logic        rd;
    logic [31:0] pc;
    logic [31:0] addr;
    logic [19:0] t;
    logic        ev;
    logic        ec;
    logic [19:0] ed;
  } vec_t;

  localparam int NV = 34;
  // PC 0x100 / 0x200 / 0x300 share set 0 (pc[4:0]=0).
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h100, 32'h10, 20'd0,    1'b1, 1'b0, 20'd0},    // R4 alloc
    '{1'b1, 32'h100, 32'h20, 20'd5,    1'b1, 1'b0, 20'd0},    // R7 no resample
    '{1'b1, 32'h100, 32'h10, 20'd20,   1'b1, 1'b0, 20'd0},    // R6 replace -> 20
    '{1'b1, 32'h100, 32'h10, 20'd40,   1'b1, 1'b0, 20'd0},    // R5 conf1
    '{1'b1, 32'h100, 32'h10, 20'd57,   1'b1, 1'b0, 20'd0},    // R5 conf2
    '{1'b1, 32'h100, 32'h10, 20'd88,   1'b1, 1'b1, 20'd20},   // R3 confident
    '{1'b1, 32'h100, 32'h10, 20'd100,  1'b1, 1'b1, 20'd20},   // R6 conf3->2
    '{1'b1, 32'h100, 32'h10, 20'd1100, 1'b1, 1'b1, 20'd20},   // R6 ->1
    '{1'b1, 32'h100, 32'h10, 20'd2100, 1'b1, 1'b0, 20'd0},    // R6 ->0
    '{1'b1, 32'h100, 32'h10, 20'd3100, 1'b1, 1'b0, 20'd0},    // R6 replace -> 1000
    '{1'b1, 32'h100, 32'h10, 20'd3612, 1'b1, 1'b0, 20'd0},    // R5 512 agrees
    '{1'b1, 32'h100, 32'h10, 20'd4123, 1'b1, 1'b0, 20'd0},    // R5 511 differs
    '{1'b1, 32'h100, 32'h10, 20'd4635, 1'b1, 1'b0, 20'd0},    // R5
    '{1'b1, 32'h100, 32'h10, 20'd5635, 1'b1, 1'b0, 20'd0},    // R5
    '{1'b1, 32'h100, 32'h10, 20'd6635, 1'b1, 1'b1, 20'd1000}, // R5
    '{1'b1, 32'h100, 32'h10, 20'd7635, 1'b1, 1'b1, 20'd1000}, // R5 saturate
    '{1'b1, 32'h100, 32'h10, 20'd8635, 1'b1, 1'b1, 20'd1000}, // R5
    '{1'b0, 32'h100, 32'h10, 20'd8640, 1'b0, 1'b0, 20'd0},    // R2 writeback
    '{1'b1, 32'h100, 32'h10, 20'd9635, 1'b1, 1'b1, 20'd1000}, // R2 sample intact
    '{1'b1, 32'h100, 32'h10, 20'd9640, 1'b1, 1'b1, 20'd1000}, // R6
    '{1'b1, 32'h100, 32'h10, 20'd9645, 1'b1, 1'b1, 20'd1000}, // R2 R6
    '{1'b1, 32'h100, 32'h10, 20'd9650, 1'b1, 1'b0, 20'd0},    // R6
    '{1'b1, 32'h100, 32'h10, 20'd9655, 1'b1, 1'b0, 20'd0},    // R6
    '{1'b1, 32'h200, 32'h40, 20'd10000, 1'b1, 1'b0, 20'd0},   // R4
    '{1'b1, 32'h200, 32'h50, 20'd10003, 1'b1, 1'b0, 20'd0},   // R7
    '{1'b1, 32'h200, 32'h50, 20'd10010, 1'b1, 1'b0, 20'd0},   // R7
    '{1'b1, 32'h200, 32'h40, 20'd10100, 1'b1, 1'b0, 20'd0},   // R7 -> 100
    '{1'b1, 32'h200, 32'h40, 20'd10200, 1'b1, 1'b0, 20'd0},   // R7
    '{1'b1, 32'h200, 32'h40, 20'd10300, 1'b1, 1'b0, 20'd0},   // R7
    '{1'b1, 32'h200, 32'h40, 20'd10400, 1'b1, 1'b1, 20'd100}, // R7
    '{1'b1, 32'h300, 32'h40, 20'd10450, 1'b1, 1'b0, 20'd0},   // R10
    '{1'b1, 32'h200, 32'h70, 20'd10460, 1'b1, 1'b1, 20'd100}, // R10
    '{1'b1, 32'h300, 32'h70, 20'd10470, 1'b1, 1'b0, 20'd0},   // R10
    '{1'b1, 32'h200, 32'h80, 20'd10480, 1'b1, 1'b0, 20'd0}    // R10
  };

  string row_req [NV] = '{
    "R4", "R7", "R6", "R5", "R5", "R3", "R6", "R6", "R6", "R6",
    "R5", "R5", "R5", "R5", "R5", "R5", "R5", "R2", "R2", "R6",
    "R2", "R6", "R6", "R4", "R7", "R7", "R7", "R7", "R7", "R7",
    "R10", "R10", "R10", "R10"
  };

  task automatic check(input string req, input logic ev, input logic ec, input logic [19:0] ed);
    n_chk++;
    if (pred_vld !== ev || (ev && (pred_conf !== ec || pred_dist !== ed))) begin
      n_err++;
      $display("FAIL %s: got vld=%0b conf=%0b dist=%0d, expected vld=%0b conf=%0b dist=%0d",
               req, pred_vld, pred_conf, pred_dist, ev, ec, ed);
    end
  endtask

  // Presents one access for one cycle (driven at a falling edge), checks the response.
  task automatic access(input logic rd, input logic [31:0] pc, input logic [31:0] addr,
                        input logic [19:0] t, input string req,
                        input logic ev, input logic ec, input logic [19:0] ed);
    acc_valid = 1'b1;
    acc_read  = rd;
    acc_pc    = pc;
    acc_addr  = addr;
    acc_time  = t;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, ev, ec, ed);
  endtask

  task automatic idle_at(input logic [19:0] t);
    acc_valid = 1'b0;
    acc_time  = t;
    @(negedge clk);
  endtask

  // Four reads two apart, then a confident answer of 2.
  task automatic train(input logic [31:0] pc, input logic [31:0] addr, input logic [19:0] t0);
    for (int k = 0; k < 4; k++) access(1'b1, pc, addr, t0 + 20'(2 * k), "R9", 1'b1, 1'b0, 20'd0);
    access(1'b1, pc, addr, t0 + 20'd8, "R9", 1'b1, 1'b1, 20'd2);
  endtask

  initial begin
    rst_n     = 1'b0;
    acc_valid = 1'b0;
    acc_read  = 1'b0;
    acc_pc    = '0;
    acc_addr  = '0;
    acc_time  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    n_chk++;
    if (pred_vld !== 1'b0 || pred_conf !== 1'b0 || pred_dist !== 20'd0) begin
      n_err++;
      $display("FAIL R1: got vld=%0b conf=%0b dist=%0d, expected 0 0 0", pred_vld, pred_conf, pred_dist);
    end

    // Vector walk: training, decay, writebacks, resampling, cross-PC matches.
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].rd, VECS[i].pc, VECS[i].addr, VECS[i].t, row_req[i],
             VECS[i].ev, VECS[i].ec, VECS[i].ed);
    end

    // R8: aged-out samples resolve as the maximum distance (PC 0x401, set 1).
    access(1'b1, 32'h401, 32'h90, 20'h00100, "R1", 1'b1, 1'b0, 20'd0);
    idle_at(20'h000FF);
    access(1'b1, 32'h401, 32'hA0, 20'h00200, "R8", 1'b1, 1'b0, 20'd0);
    idle_at(20'h001FF);
    access(1'b1, 32'h401, 32'hA0, 20'h00300, "R8", 1'b1, 1'b0, 20'd0);
    idle_at(20'h002FF);
    access(1'b1, 32'h401, 32'hA0, 20'h00400, "R8", 1'b1, 1'b1, 20'hFFFFF);

    // R9: set 2 replacement order.
    train(32'h22, 32'h1000, 20'h1000);  // P0
    train(32'h42, 32'h1100, 20'h1010);  // P1
    for (int k = 2; k < 8; k++) begin
      access(1'b1, 32'((k + 1) << 5) | 32'h2, 32'h2000 + 32'(k << 8),
             20'h1020 + 20'(2 * k), "R9", 1'b1, 1'b0, 20'd0);
    end
    access(1'b1, 32'h22, 32'h1000, 20'h1040, "R9", 1'b1, 1'b1, 20'd2);  // P0 becomes MRU
    access(1'b1, 32'h122, 32'h2900, 20'h1042, "R9", 1'b1, 1'b0, 20'd0); // fill evicts P1
    access(1'b1, 32'h42, 32'h1100, 20'h1044, "R9", 1'b1, 1'b0, 20'd0);  // P1 gone
    access(1'b1, 32'h22, 32'h1000, 20'h1046, "R9", 1'b1, 1'b1, 20'd2);  // P0 kept

    // R2: a lone writeback gives no response.
    access(1'b0, 32'h22, 32'h1000, 20'h1048, "R2", 1'b0, 1'b0, 20'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (R1): got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule